// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block sits at the head of the queue of packets that the host sends to the device. Each packet is a fixed number of 32-bit words long. The first two words are a header: a flags/channel/length word and a 32-bit timestamp. The scheduler reads this header and compares the timestamp with a free-running sample-time counter. It then releases the payload to the DAC sample stream at that exact tick, at the rate of one 32-bit sample per tick. Packets whose moment has already gone by are thrown away whole and reported by a one-cycle pulse. A timestamp of all ones means "now" and skips the comparison.

Packets addressed to the control channel follow the same timing rule. Their payload words are forwarded on a separate valid/ready word stream to a control executor instead of the DAC. The block also keeps track of burst boundaries from the start and end flags of data packets. It reports an underrun when a sample tick goes by without a sample in the middle of a burst, and it stays silent between bursts.

The input stream is valid/ready. A word is taken when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` depends only on the scheduler state, `tick` and `ctl_ready`, never on `in_valid`. The control stream is valid/ready. It is a passthrough of the queue, so while `ctl_ready` is low the queue is held and `ctl_valid`/`ctl_data` stay put. The DAC side has no back-pressure: it produces one output cycle for each `tick`.

Top module: `txq_time_sched`

## Requirements
- R1: Header word 0 carries the payload length in bytes at bits 8:0, the channel at bits 20:16, start-of-burst at bit 28 and end-of-burst at bit 27. Header word 1 is the 32-bit timestamp.
- R2: When the timestamp lies in the future, no live sample is produced until the counter equals it. The first payload sample then appears live on the DAC output while the counter reads timestamp+2. The following samples come one per tick with no gap.
- R3: A timestamp of 0xFFFFFFFF releases the packet immediately, whatever the counter value.
- R4: A packet counts as late when (now − timestamp), taken as a signed 32-bit value, is above zero. This comparison works across counter wrap. A late packet produces no samples and raises `drop_pulse` for exactly one cycle.
- R5: A length above (PKT_WORDS−2)·4 bytes is treated as dropped (one `drop_pulse`, no samples). A length of zero releases no samples and raises no drop.
- R6: Every packet takes exactly PKT_WORDS words from the queue. Padding words after the payload are consumed and ignored, so the next header is parsed correctly.
- R7: On channel 31, the ⌈length/4⌉ payload words go out on `ctl_data` with `ctl_last` on the final word. No DAC sample is live during this time. While `ctl_ready` is low, no word is consumed.
- R8: `underrun_pulse` fires on a tick that yields no live sample while a burst is open. A burst opens when a data packet with the start flag is released and closes after the last sample of a packet with the end flag. No underrun is raised outside a burst.
- R9: Each `tick` produces exactly one DAC output cycle (`dac_strobe`) on the next clock. `dac_data` holds a payload word when `dac_live` is high, and zero otherwise.
- R10: A data packet releases exactly ⌈length/4⌉ samples, in queue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample-clock enable, one per DAC sample |
| now | input | 32 | Free-running sample-time counter |
| in_data | input | 32 | Queue head word |
| in_valid | input | 1 | Queue head word present |
| in_ready | output | 1 | Scheduler takes the head word |
| dac_data | output | 32 | DAC sample (zero when not live) |
| dac_strobe | output | 1 | One DAC output cycle, follows each tick |
| dac_live | output | 1 | Sample on dac_data is payload |
| ctl_data | output | 32 | Control payload word |
| ctl_valid | output | 1 | Control word present |
| ctl_ready | input | 1 | Control executor accepts word |
| ctl_last | output | 1 | Final control payload word of the packet |
| drop_pulse | output | 1 | One-cycle pulse per discarded packet |
| underrun_pulse | output | 1 | One-cycle pulse per starved tick inside a burst |

## Verification
The bench builds the block with PKT_WORDS = 16. This makes the payload limit 56 bytes, so the over-range case (57 bytes) and packets that are mostly padding can be reached within a handful of words. With `tick` high on every cycle, the counter advances each clock, which makes the two-tick release latency and the back-to-back sample spacing exact. The counter is loaded just below its wrap point to test the signed late/future decision across zero.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 9;
  localparam int CHAN_W   = 5;
  localparam int LEN_LSB  = 0;
  localparam int CHAN_LSB = 16;
  localparam int SOB_BIT  = 28;
  localparam int EOB_BIT  = 27;
  localparam logic [CHAN_W-1:0] CTRL_CHAN = 5'h1f;
  localparam logic [WORD_W-1:0] TS_NOW    = '1;

  typedef enum logic [2:0] {
    ST_HDR0, ST_HDR1, ST_WAIT, ST_PLAY, ST_CTRL, ST_SKIP
  } seq_state_e;

  typedef enum logic [1:0] {
    VD_HOLD, VD_GO, VD_DROP
  } verdict_e;
endpackage

// File: rtl/txq_time_gate.sv
module txq_time_gate
  import txq_pkg::*;
#(
  parameter int MAX_BYTES = 504
) (
  input  logic [WORD_W-1:0] now,
  input  logic [WORD_W-1:0] ts,
  input  logic [LEN_W-1:0]  len,
  output verdict_e          verdict
);
  logic signed [WORD_W-1:0] delta;
  logic len_bad, is_now, is_late, is_due;

  always_comb begin
    delta   = $signed(now - ts);
    len_bad = int'(len) > MAX_BYTES;
    is_now  = (ts == TS_NOW);
    is_late = !is_now && (delta > 0);
    is_due  = is_now || (now == ts);
    if (len_bad || is_late) verdict = VD_DROP;
    else if (is_due)        verdict = VD_GO;
    else                    verdict = VD_HOLD;
  end
endmodule

// File: rtl/txq_seq.sv
module txq_seq
  import txq_pkg::*;
#(
  parameter int PKT_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  verdict_e          verdict,
  output logic [WORD_W-1:0] ts_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic              ctl_last,
  output logic              live,
  output logic              in_burst,
  output logic              drop_pulse
);
  localparam int CW   = $clog2(PKT_WORDS) + 1;
  localparam int BODY = PKT_WORDS - 2;

  seq_state_e        state;
  logic [CHAN_W-1:0] chan_q;
  logic              sob_q, eob_q;
  logic [CW-1:0]     rem, pay;
  logic [LEN_W:0]    nwords_full;
  logic [CW-1:0]     nwords;
  logic              pop;

  assign nwords_full = ({1'b0, len_q} + (LEN_W+1)'(3)) >> 2;
  assign nwords      = CW'(nwords_full);

  always_comb begin
    unique case (state)
      ST_HDR0, ST_HDR1, ST_SKIP: in_ready = 1'b1;
      ST_PLAY:                   in_ready = tick;
      ST_CTRL:                   in_ready = ctl_ready;
      default:                   in_ready = 1'b0;
    endcase
  end

  assign pop       = in_valid && in_ready;
  assign live      = (state == ST_PLAY) && pop;
  assign ctl_valid = (state == ST_CTRL) && in_valid;
  assign ctl_last  = ctl_valid && (pay == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HDR0;
      ts_q       <= '0;
      len_q      <= '0;
      chan_q     <= '0;
      sob_q      <= 1'b0;
      eob_q      <= 1'b0;
      rem        <= '0;
      pay        <= '0;
      in_burst   <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      drop_pulse <= 1'b0;
      unique case (state)
        ST_HDR0: if (pop) begin
          len_q  <= in_data[LEN_LSB +: LEN_W];
          chan_q <= in_data[CHAN_LSB +: CHAN_W];
          sob_q  <= in_data[SOB_BIT];
          eob_q  <= in_data[EOB_BIT];
          state  <= ST_HDR1;
        end
        ST_HDR1: if (pop) begin
          ts_q  <= in_data;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          rem <= CW'(BODY);
          pay <= nwords;
          if (verdict == VD_DROP) begin
            drop_pulse <= 1'b1;
            state      <= ST_SKIP;
          end else if (verdict == VD_GO) begin
            if (chan_q != CTRL_CHAN) begin
              if (sob_q) in_burst <= 1'b1;
              if (nwords == '0 && eob_q) in_burst <= 1'b0;
            end
            if (nwords == '0)            state <= ST_SKIP;
            else if (chan_q == CTRL_CHAN) state <= ST_CTRL;
            else                          state <= ST_PLAY;
          end
        end
        ST_PLAY, ST_CTRL: if (pop) begin
          rem <= rem - CW'(1);
          pay <= pay - CW'(1);
          if (pay == CW'(1)) begin
            if (state == ST_PLAY && eob_q) in_burst <= 1'b0;
            state <= (rem == CW'(1)) ? ST_HDR0 : ST_SKIP;
          end
        end
        ST_SKIP: if (pop) begin
          rem <= rem - CW'(1);
          if (rem == CW'(1)) state <= ST_HDR0;
        end
        default: state <= ST_HDR0;
      endcase
    end
  end
endmodule

// File: rtl/txq_dac_out.sv
module txq_dac_out
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              live,
  input  logic              in_burst,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] dac_data,
  output logic              dac_strobe,
  output logic              dac_live,
  output logic              underrun_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data       <= '0;
      dac_strobe     <= 1'b0;
      dac_live       <= 1'b0;
      underrun_pulse <= 1'b0;
    end else begin
      dac_strobe     <= tick;
      dac_live       <= tick && live;
      dac_data       <= (tick && live) ? word : '0;
      underrun_pulse <= tick && !live && in_burst;
    end
  end
endmodule

// File: rtl/txq_time_sched.sv
module txq_time_sched
  import txq_pkg::*;
#(
  parameter int PKT_WORDS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [31:0] now,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] dac_data,
  output logic        dac_strobe,
  output logic        dac_live,
  output logic [31:0] ctl_data,
  output logic        ctl_valid,
  input  logic        ctl_ready,
  output logic        ctl_last,
  output logic        drop_pulse,
  output logic        underrun_pulse
);
  localparam int MAX_BYTES = (PKT_WORDS - 2) * 4;

  logic [WORD_W-1:0] ts_q;
  logic [LEN_W-1:0]  len_q;
  verdict_e          verdict;
  logic              live, in_burst;

  assign ctl_data = in_data;

  txq_time_gate #(.MAX_BYTES(MAX_BYTES)) u_gate (
    .now(now), .ts(ts_q), .len(len_q), .verdict(verdict)
  );

  txq_seq #(.PKT_WORDS(PKT_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .verdict(verdict), .ts_q(ts_q), .len_q(len_q),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_last(ctl_last),
    .live(live), .in_burst(in_burst), .drop_pulse(drop_pulse)
  );

  txq_dac_out u_dac (
    .clk(clk), .rst_n(rst_n), .tick(tick), .live(live),
    .in_burst(in_burst), .word(in_data),
    .dac_data(dac_data), .dac_strobe(dac_strobe), .dac_live(dac_live),
    .underrun_pulse(underrun_pulse)
  );
endmodule

// File: rtl/txq_time_sched_chk.sv
module txq_time_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic dac_strobe,
  input logic dac_live,
  input logic ctl_valid,
  input logic ctl_ready,
  input logic drop_pulse,
  input logic underrun_pulse
);
  p_strobe_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dac_strobe == $past(tick)));

  p_live_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dac_live |-> dac_strobe);

  p_urun_idle_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_pulse |-> (dac_strobe && !dac_live));

  p_drop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !drop_pulse);

  p_ctl_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_ready) |=> ctl_valid);

  p_ctl_no_dac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !dac_live);
endmodule

bind txq_time_sched txq_time_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dac_strobe(dac_strobe),
  .dac_live(dac_live), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
  .drop_pulse(drop_pulse), .underrun_pulse(underrun_pulse)
);

// File: tb/txq_time_sched_tb_top.sv
`timescale 1ns/1ps
module txq_time_sched_tb_top;
  localparam int PW = 16;
  localparam int MAXB = (PW - 2) * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [31:0] now_r = 32'd0;
  logic ld = 1'b0;
  logic [31:0] ld_val = '0;
  logic [31:0] in_data;
  logic in_valid, in_ready;
  logic [31:0] dac_data, ctl_data;
  logic dac_strobe, dac_live, ctl_valid, ctl_last, drop_pulse, underrun_pulse;
  logic ctl_ready = 1'b1;

  always #2 clk = ~clk;

  logic [31:0] mem [0:1023];
  int wr = 0;
  int rd;
  assign in_valid = (rd != wr);
  assign in_data  = mem[rd[9:0]];

  always @(posedge clk) begin
    if (!rst_n) rd <= 0;
    else if (in_valid && in_ready) rd <= rd + 1;
    if (ld) now_r <= ld_val;
    else if (tick) now_r <= now_r + 32'd1;
  end

  txq_time_sched #(.PKT_WORDS(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(now_r),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .dac_data(dac_data), .dac_strobe(dac_strobe), .dac_live(dac_live),
    .ctl_data(ctl_data), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_last(ctl_last), .drop_pulse(drop_pulse), .underrun_pulse(underrun_pulse)
  );

  // monitor
  logic [31:0] smp [0:63];
  logic [31:0] cw  [0:15];
  int nsmp, ndrop, nurun, nctl, last_idx, nstrobe;
  logic [31:0] first_now, last_now;

  always @(negedge clk) begin
    if (dac_strobe) nstrobe++;
    if (dac_strobe && dac_live) begin
      if (nsmp == 0) first_now = now_r;
      last_now = now_r;
      if (nsmp < 64) smp[nsmp] = dac_data;
      nsmp++;
    end
    if (drop_pulse) ndrop++;
    if (underrun_pulse) nurun++;
    if (ctl_valid && ctl_ready) begin
      if (nctl < 16) cw[nctl] = ctl_data;
      if (ctl_last) last_idx = nctl;
      nctl++;
    end
  end

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk); #1;
    nsmp = 0; ndrop = 0; nurun = 0; nctl = 0; last_idx = -1; nstrobe = 0;
    first_now = '0; last_now = '0;
  endtask

  task automatic push_pkt(input bit sob, input bit eob, input logic [4:0] ch,
                          input logic [8:0] len, input logic [31:0] ts,
                          input logic [31:0] base);
    int nw;
    @(negedge clk);
    nw = (int'(len) + 3) / 4;
    mem[wr[9:0]] = {3'b0, sob, eob, 6'b0, ch, 7'b0, len};
    mem[(wr + 1) % 1024] = ts;
    for (int i = 0; i < PW - 2; i++)
      mem[(wr + 2 + i) % 1024] = (i < nw) ? base + 32'(i) : 32'hDEAD0000 + 32'(i);
    wr = wr + PW;
  endtask

  task automatic load_now(input logic [31:0] v);
    @(negedge clk); ld = 1'b1; ld_val = v;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R6 reset in_ready", in_ready, 1);
    chk(!dac_live && !drop_pulse && !underrun_pulse && !ctl_valid,
        "R9 reset outputs quiet", {dac_live, drop_pulse, underrun_pulse, ctl_valid}, 0);
  endtask

  task automatic t_timed();
    logic [31:0] ts;
    mon_clear();
    ts = now_r + 32'd30;
    push_pkt(0, 0, 5'd2, 9'd12, ts, 32'hA000_0000);
    repeat (70) @(posedge clk);
    @(negedge clk);
    chk(nsmp == 3, "R10 timed sample count", nsmp, 3);
    chk(smp[0] == 32'hA000_0000 && smp[2] == 32'hA000_0002, "R10 timed order", smp[2], 32'hA000_0002);
    chk(first_now == ts + 32'd2, "R2 release tick", first_now, ts + 32'd2);
    chk(last_now - first_now == 32'd2, "R2 back-to-back", last_now - first_now, 2);
    chk(ndrop == 0 && nurun == 0, "R8 no events outside burst", ndrop + nurun, 0);
    chk(nstrobe > 60, "R9 strobe per tick", nstrobe, 60);
  endtask

  task automatic t_now_wild();
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'd5, 32'hFFFF_FFFF, 32'hB000_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(nsmp == 2, "R3 wildcard released", nsmp, 2);
    chk(smp[1] == 32'hB000_0001, "R6 next header after padding", smp[1], 32'hB000_0001);
  endtask

  task automatic t_late();
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'd8, now_r - 32'd5, 32'hC000_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(ndrop == 1, "R4 late dropped once", ndrop, 1);
    chk(nsmp == 0, "R4 late no samples", nsmp, 0);
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'd4, 32'hFFFF_FFFF, 32'hC100_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(nsmp == 1 && smp[0] == 32'hC100_0000, "R6 after drop", smp[0], 32'hC100_0000);
  endtask

  task automatic t_len_edges();
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'(MAXB + 1), 32'hFFFF_FFFF, 32'hD000_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(ndrop == 1 && nsmp == 0, "R5 over-range dropped", ndrop * 100 + nsmp, 100);
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'd0, 32'hFFFF_FFFF, 32'hD100_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(ndrop == 0 && nsmp == 0, "R5 zero length silent", ndrop * 100 + nsmp, 0);
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'(MAXB), 32'hFFFF_FFFF, 32'hD200_0000);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(nsmp == PW - 2 && smp[PW-3] == 32'hD200_0000 + 32'(PW - 3),
        "R10 full payload", nsmp, PW - 2);
  endtask

  task automatic t_ctrl();
    mon_clear();
    @(negedge clk); ctl_ready = 1'b0;
    push_pkt(0, 0, 5'h1f, 9'd8, 32'hFFFF_FFFF, 32'hE000_0000);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(nctl == 0 && ctl_valid, "R7 stalled", nctl, 0);
    ctl_ready = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(nctl == 2 && cw[0] == 32'hE000_0000 && cw[1] == 32'hE000_0001, "R7 ctl words", nctl, 2);
    chk(last_idx == 1, "R7 ctl_last", last_idx, 1);
    chk(nsmp == 0, "R7 no DAC samples", nsmp, 0);
    chk(rd == wr, "R1 channel decode consumed", rd, wr);
  endtask

  task automatic t_burst();
    mon_clear();
    push_pkt(1, 0, 5'd3, 9'd8, 32'hFFFF_FFFF, 32'hF000_0000);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(nsmp == 2, "R1 start flag packet plays", nsmp, 2);
    chk(nurun > 10, "R8 underrun in burst", nurun, 10);
    push_pkt(0, 1, 5'd3, 9'd4, 32'hFFFF_FFFF, 32'hF100_0000);
    repeat (30) @(posedge clk);
    mon_clear();
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(nurun == 0, "R8 silent after end flag", nurun, 0);
  endtask

  task automatic t_wrap();
    load_now(32'hFFFF_FFF0);
    mon_clear();
    push_pkt(0, 0, 5'd1, 9'd4, 32'h0000_0008, 32'h1234_0000);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(ndrop == 0, "R4 wrap not late", ndrop, 0);
    chk(nsmp == 1 && first_now == 32'h0000_000A, "R2 wrap release tick", first_now, 32'h0000_000A);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timed();
    t_now_wild();
    t_late();
    t_len_edges();
    t_ctrl();
    t_burst();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule